// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block drives the mode-register setup that a DRAM device needs once its supply and clock are stable. A one-cycle start pulse, qualified by a two-bit device kind, launches a fixed list of commands. Each command goes to the memory controller's command port as a 32-bit word together with a one-cycle write strobe. The port reports through a pending flag that the command is still in flight. Before it presents the next word, the sequencer waits a minimum launch interval and then for the pending flag to clear. A few steps carry an extra settle gap on top of that. Both the launch interval and the gaps are counted in clock cycles from a cycles-per-microsecond parameter.

For DDR3 the list is: deselect, precharge-all, the four mode registers in the order 2, 3, 1, 0 with the DLL-reset bit forced into register 0, and a long ZQ calibration. For the low-power families the list is: a device reset, two calibration writes, mode registers 1 to 3, and for LPDDR3 only a final write of register 11. The mode-register values are static configuration inputs. They must be held stable while the sequence runs.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycles after it, `busy_o`, `done_o` and `cmd_wr_o` are 0.
- R2: Every command word has bit 31 set (start flag), bits [21:20] = 2'b11 (both ranks), bits [30:22] = 0, and bits [3:0] holding the command code: 1 deselect, 2 precharge-all, 3 mode-register write, 4 long ZQ calibration.
- R3: With kind 0 (DDR3) the words are, in order: deselect, precharge-all, mode writes to bank 2, 3, 1 and 0, then ZQ calibration. A mode write puts the bank number in [19:17] and the low 13 bits of the register in [16:4]. All other argument bits are 0.
- R4: For the DDR3 bank-0 write, bit 8 of the 13-bit value field (word bit 12) is 1, whatever the value of `mr0_i[8]`. The other bits are copied from `mr0_i`.
- R5: With a low-power kind, every word is a mode write with the mode address in [19:12] and the operand in [11:4]. The order is: address 0x63 with operand 0x00, address 0x10 with operand 0xFF twice, then addresses 1, 2 and 3 with the low bytes of `mr1_i`, `mr2_i` and `mr3_i`.
- R6: Kind 1 (LPDDR2) ends after address 3. Kinds 2 and 3 (LPDDR3) append address 11 with `mr11_i` as the operand.
- R7: `cmd_wr_o` is high for exactly one cycle per command. The first command appears in the cycle after start is sampled. After a command presented in cycle k, the next appears in cycle j+1+G, where j is the first cycle at or after k+C+1 in which the sampled pending flag is low, C is CYCLES_PER_US, and G is the step's settle gap.
- R8: The settle gap G is 1·C after deselect, 10·C after address 0x63, 1·C after each address-0x10 write, and 0 after every other step.
- R9: `busy_o` is high from the cycle after start through cycle j of the last command. `done_o` pulses for one cycle at j+1, when `busy_o` has fallen.
- R10: A start pulse while busy has no effect, and the device kind is captured only when start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dram_type_i | input | 2 | Device kind: 0 DDR3, 1 LPDDR2, 2/3 LPDDR3 |
| mr0_i | input | MR_W | Mode register 0 value |
| mr1_i | input | MR_W | Mode register 1 value |
| mr2_i | input | MR_W | Mode register 2 value |
| mr3_i | input | MR_W | Mode register 3 value |
| mr11_i | input | 8 | Mode register 11 value (LPDDR3) |
| cmd_pending_i | input | 1 | Command port still holds the previous command |
| cmd_wr_o | output | 1 | One-cycle command write strobe |
| cmd_word_o | output | 32 | Command word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong step index or a wrong latched kind shows up as a wrong word the first time the strobe rises, so it is caught within one command. A timer or state error moves a strobe or the done pulse off its predicted cycle by at least one clock. The bench compares the strobe, busy and done on every cycle, so such an error appears at the first command that follows it. Pending-flag latencies shorter and longer than the launch interval exercise both exits of the wait for command completion.

// File: rtl/dram_seq_pkg.sv
// Shared command encodings, device kinds and step descriptor for the
// power-up sequencer. Assumes a 32-bit command word with the rank field
// at bits [21:20].
package dram_seq_pkg;

    typedef enum logic [1:0] {
        DK_DDR3   = 2'd0,
        DK_LPDDR2 = 2'd1,
        DK_LPDDR3 = 2'd2,
        DK_LP3ALT = 2'd3
    } dram_kind_e;

    localparam logic [3:0] OP_DESEL = 4'd1;
    localparam logic [3:0] OP_PREA  = 4'd2;
    localparam logic [3:0] OP_MRS   = 4'd3;
    localparam logic [3:0] OP_ZQCL  = 4'd4;

    localparam int STEP_W     = 3;
    localparam int MAX_GAP_US = 10;
    localparam int DDR3_VAL_W = 13;

    typedef struct packed {
        logic [31:0] word;
        logic [3:0]  gap_us;
        logic        last;
    } step_t;

    // Word for a DDR3-style command: bank in [19:17], value in [16:4].
    function automatic logic [31:0] ddr3_word(input logic [3:0] op,
                                              input logic [2:0] bank,
                                              input logic [DDR3_VAL_W-1:0] val);
        return {1'b1, 9'd0, 2'b11, bank, val, op};
    endfunction

    // Word for a low-power mode write: address in [19:12], operand in [11:4].
    function automatic logic [31:0] lp_word(input logic [7:0] ma,
                                            input logic [7:0] opnd);
        return {1'b1, 9'd0, 2'b11, ma, opnd, OP_MRS};
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
// Down-counting interval timer. A load sets the count; it then falls by
// one per cycle until zero. Assumes the loaded value fits CNT_W bits.
module dram_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: load, decrement, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R7
    stays_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/dram_seq_rom.sv
// Step table: maps device kind and step index to a command word, its
// settle gap in microseconds, and an end-of-list flag. Purely combinational.
// Assumes the mode-register inputs are stable during a sequence.
module dram_seq_rom
    import dram_seq_pkg::*;
#(
    parameter int MR_W = 13
) (
    input  dram_kind_e        kind_i,
    input  logic [STEP_W-1:0] idx_i,
    input  logic [MR_W-1:0]   mr0_i,
    input  logic [MR_W-1:0]   mr1_i,
    input  logic [MR_W-1:0]   mr2_i,
    input  logic [MR_W-1:0]   mr3_i,
    input  logic [7:0]        mr11_i,
    output step_t             step_o
);

    localparam logic [DDR3_VAL_W-1:0] DLL_RST = DDR3_VAL_W'(13'h100);

    logic [DDR3_VAL_W-1:0] v0, v1, v2, v3;
    logic                  lp3;

    // Fit the register inputs to the DDR3 value field.
    always_comb begin
        v0 = DDR3_VAL_W'(mr0_i);
        v1 = DDR3_VAL_W'(mr1_i);
        v2 = DDR3_VAL_W'(mr2_i);
        v3 = DDR3_VAL_W'(mr3_i);
    end

    assign lp3 = kind_i[1];

    // Select the descriptor for the current step.
    always_comb begin
        step_o = '{word: 32'd0, gap_us: 4'd0, last: 1'b1};
        if (kind_i == DK_DDR3) begin
            case (idx_i)
                3'd0: step_o = '{ddr3_word(OP_DESEL, 3'd0, '0), 4'd1, 1'b0};
                3'd1: step_o = '{ddr3_word(OP_PREA,  3'd0, '0), 4'd0, 1'b0};
                3'd2: step_o = '{ddr3_word(OP_MRS,   3'd2, v2), 4'd0, 1'b0};
                3'd3: step_o = '{ddr3_word(OP_MRS,   3'd3, v3), 4'd0, 1'b0};
                3'd4: step_o = '{ddr3_word(OP_MRS,   3'd1, v1), 4'd0, 1'b0};
                3'd5: step_o = '{ddr3_word(OP_MRS,   3'd0, v0 | DLL_RST), 4'd0, 1'b0};
                3'd6: step_o = '{ddr3_word(OP_ZQCL,  3'd0, '0), 4'd0, 1'b1};
                default: step_o = '{word: 32'd0, gap_us: 4'd0, last: 1'b1};
            endcase
        end else begin
            case (idx_i)
                3'd0: step_o = '{lp_word(8'h63, 8'h00), 4'(MAX_GAP_US), 1'b0};
                3'd1: step_o = '{lp_word(8'h10, 8'hFF), 4'd1, 1'b0};
                3'd2: step_o = '{lp_word(8'h10, 8'hFF), 4'd1, 1'b0};
                3'd3: step_o = '{lp_word(8'd1, mr1_i[7:0]), 4'd0, 1'b0};
                3'd4: step_o = '{lp_word(8'd2, mr2_i[7:0]), 4'd0, 1'b0};
                3'd5: step_o = '{lp_word(8'd3, mr3_i[7:0]), 4'd0, !lp3};
                3'd6: step_o = '{lp_word(8'd11, mr11_i), 4'd0, 1'b1};
                default: step_o = '{word: 32'd0, gap_us: 4'd0, last: 1'b1};
            endcase
        end
    end

endmodule

// File: rtl/dram_init_seq.sv
// Power-up mode-register sequencer. Walks the step table for the latched
// device kind, presents each word with a one-cycle strobe, waits the
// launch interval, then the port's pending flag, then the step's settle
// gap. Assumes the port raises pending within the launch interval.
module dram_init_seq
    import dram_seq_pkg::*;
#(
    parameter int CYCLES_PER_US = 8,
    parameter int MR_W          = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      dram_type_i,
    input  logic [MR_W-1:0] mr0_i,
    input  logic [MR_W-1:0] mr1_i,
    input  logic [MR_W-1:0] mr2_i,
    input  logic [MR_W-1:0] mr3_i,
    input  logic [7:0]      mr11_i,
    input  logic            cmd_pending_i,
    output logic            cmd_wr_o,
    output logic [31:0]     cmd_word_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam int CNT_W   = $clog2(MAX_GAP_US * CYCLES_PER_US + 1);
    localparam int SPACE   = CYCLES_PER_US + 2;
    localparam int SPACE_W = $clog2(SPACE + 1);

    typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_LAUNCH, S_POLL, S_GAP} seq_state_e;

    seq_state_e        state_q;
    logic [STEP_W-1:0] idx_q;
    dram_kind_e        kind_q;
    logic              done_q;
    step_t             step;
    logic              tmr_load, tmr_expired, port_free, has_gap;
    logic [CNT_W-1:0]  tmr_val;

    dram_seq_rom #(.MR_W(MR_W)) u_rom (
        .kind_i (kind_q),
        .idx_i  (idx_q),
        .mr0_i  (mr0_i),
        .mr1_i  (mr1_i),
        .mr2_i  (mr2_i),
        .mr3_i  (mr3_i),
        .mr11_i (mr11_i),
        .step_o (step)
    );

    dram_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    assign port_free = !cmd_pending_i;
    assign has_gap   = (step.gap_us != 4'd0);

    // Timer load: launch interval on issue, settle gap after completion.
    always_comb begin
        tmr_load = (state_q == S_ISSUE) || (state_q == S_POLL && port_free && has_gap);
        if (state_q == S_ISSUE)
            tmr_val = CNT_W'(CYCLES_PER_US - 1);
        else
            tmr_val = CNT_W'(int'(step.gap_us) * CYCLES_PER_US - 1);
    end

    // Sequencer state, step index, latched kind and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            kind_q  <= DK_DDR3;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    kind_q  <= dram_kind_e'(dram_type_i);
                    idx_q   <= '0;
                    state_q <= S_ISSUE;
                end
                S_ISSUE:  state_q <= S_LAUNCH;
                S_LAUNCH: if (tmr_expired) state_q <= S_POLL;
                S_POLL: if (port_free) begin
                    if (has_gap) begin
                        state_q <= S_GAP;
                    end else if (step.last) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_ISSUE;
                    end
                end
                S_GAP: if (tmr_expired) begin
                    if (step.last) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_ISSUE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign cmd_wr_o   = (state_q == S_ISSUE);
    assign cmd_word_o = step.word;
    assign busy_o     = (state_q != S_IDLE);
    assign done_o     = done_q;

    // Cycles since the last strobe, saturating, for the spacing check.
    logic [SPACE_W-1:0] since_wr_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_wr_q <= '0;
        else if (cmd_wr_o)
            since_wr_q <= SPACE_W'(1);
        else if (since_wr_q != '0 && since_wr_q < SPACE_W'(SPACE))
            since_wr_q <= since_wr_q + 1'b1;
    end

    // R2
    word_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |-> (cmd_word_o[31] && cmd_word_o[21:20] == 2'b11 && cmd_word_o[30:22] == '0));

    // R7
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && since_wr_q != '0) |-> (since_wr_q >= SPACE_W'(SPACE)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R6
    no_mr11_lp2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_o && kind_q == DK_LPDDR2) |-> (cmd_word_o[19:12] != 8'd11));

endmodule

// File: tb/tb_dram_init_seq.sv
module tb_dram_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int C          = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  dram_type_i = 2'd0;
    logic [12:0] mr0_i = 13'h0421, mr1_i = 13'h0046, mr2_i = 13'h0018, mr3_i = 13'h0002;
    logic [7:0]  mr11_i = 8'h03;
    logic        cmd_pending_i = 1'b0;
    logic        cmd_wr_o, busy_o, done_o;
    logic [31:0] cmd_word_o;

    dram_init_seq #(.CYCLES_PER_US(C), .MR_W(13)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dram_type_i(dram_type_i),
        .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i), .mr11_i(mr11_i),
        .cmd_pending_i(cmd_pending_i), .cmd_wr_o(cmd_wr_o), .cmd_word_o(cmd_word_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n = 0;
    always @(posedge clk) n <= n + 1;

    int          checks = 0, fails = 0;
    string       tag = "R1";
    string       time_tag = "R7";
    logic [31:0] q_word[$];
    int          q_gap[$];
    int          next_t = -1, busy_from = 1 << 30, done_t = -1;
    int          lat = 1, pend_left = 0;

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", t, what, act, exp, n);
        end
    endtask

    function automatic logic [31:0] w3(input int op, input int bank, input int val);
        return (32'd1 << 31) | (32'd3 << 20) | (32'(bank) << 17) | (32'(val & 13'h1FFF) << 4) | 32'(op);
    endfunction

    function automatic logic [31:0] wl(input int ma, input int opnd);
        return (32'd1 << 31) | (32'd3 << 20) | (32'(ma) << 12) | (32'(opnd & 8'hFF) << 4) | 32'd3;
    endfunction

    // Reference model: expected strobe, word, busy and done every cycle.
    always @(negedge clk) begin
        bit exp_wr, exp_busy, exp_done;
        int j, g;
        if (!rst_n) begin
            // R1
            chk(busy_o == 1'b0, "R1", "busy in reset", 32'(busy_o), 0);
            chk(done_o == 1'b0, "R1", "done in reset", 32'(done_o), 0);
            chk(cmd_wr_o == 1'b0, "R1", "strobe in reset", 32'(cmd_wr_o), 0);
        end else begin
            exp_wr   = (q_word.size() > 0) && (n == next_t);
            exp_busy = (n >= busy_from) && (done_t < 0 || n < done_t);
            exp_done = (done_t >= 0) && (n == done_t);
            // R7 / R8: strobe timing
            chk(cmd_wr_o == exp_wr, time_tag, "strobe", 32'(cmd_wr_o), 32'(exp_wr));
            // R9: busy and done
            chk(busy_o == exp_busy, "R9", "busy", 32'(busy_o), 32'(exp_busy));
            chk(done_o == exp_done, "R9", "done", 32'(done_o), 32'(exp_done));
            if (cmd_wr_o && exp_wr) begin
                // R2 format, order per the test's requirement tag
                chk(cmd_word_o == q_word[0], tag, "word", cmd_word_o, q_word[0]);
                g = q_gap[0];
                void'(q_word.pop_front());
                void'(q_gap.pop_front());
                j = (n + C + 1 > n + lat) ? n + C + 1 : n + lat;
                if (q_word.size() == 0) done_t = j + 1;
                else next_t = j + 1 + g * C;
                time_tag = (g > 0) ? "R8" : "R7";
            end
            // Command-port model: pending high for lat cycles after a strobe.
            if (cmd_wr_o) begin
                cmd_pending_i = 1'b1;
                pend_left = lat - 1;
            end else if (pend_left > 0) begin
                pend_left--;
            end else begin
                cmd_pending_i = 1'b0;
            end
        end
    end

    task automatic build(input logic [1:0] kind);
        q_word.delete();
        q_gap.delete();
        if (kind == 2'd0) begin
            // R3 order, R4 DLL-reset bit in bank-0 value
            q_word.push_back(w3(1, 0, 0));            q_gap.push_back(1);
            q_word.push_back(w3(2, 0, 0));            q_gap.push_back(0);
            q_word.push_back(w3(3, 2, mr2_i));        q_gap.push_back(0);
            q_word.push_back(w3(3, 3, mr3_i));        q_gap.push_back(0);
            q_word.push_back(w3(3, 1, mr1_i));        q_gap.push_back(0);
            q_word.push_back(w3(3, 0, mr0_i | 13'h100)); q_gap.push_back(0);
            q_word.push_back(w3(4, 0, 0));            q_gap.push_back(0);
        end else begin
            // R5 order, R6 optional address 11
            q_word.push_back(wl(8'h63, 0));    q_gap.push_back(10);
            q_word.push_back(wl(8'h10, 8'hFF)); q_gap.push_back(1);
            q_word.push_back(wl(8'h10, 8'hFF)); q_gap.push_back(1);
            q_word.push_back(wl(1, mr1_i));    q_gap.push_back(0);
            q_word.push_back(wl(2, mr2_i));    q_gap.push_back(0);
            q_word.push_back(wl(3, mr3_i));    q_gap.push_back(0);
            if (kind[1]) begin
                q_word.push_back(wl(11, mr11_i)); q_gap.push_back(0);
            end
        end
    endtask

    task automatic run(input logic [1:0] kind, input int lat_v, input string t, input bit mid_start);
        int s;
        @(negedge clk);
        tag = t;
        lat = lat_v;
        time_tag = "R7";
        build(kind);
        s = n;
        busy_from = s + 1;
        done_t = -1;
        next_t = s + 1;
        start_i = 1'b1;
        dram_type_i = kind;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            // R10: start and a different kind while busy must be ignored
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            dram_type_i = 2'd0;
            @(negedge clk);
            start_i = 1'b0;
            dram_type_i = 2'd1;
        end
        while (!(done_t >= 0 && n > done_t + 1)) @(negedge clk);
        // R6 / R10: whole list consumed
        chk(q_word.size() == 0, t, "words left", 32'(q_word.size()), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle after reset
        chk(busy_o == 1'b0 && cmd_wr_o == 1'b0, "R1", "idle after reset", 32'(busy_o), 0);
        run(2'd0, 1, "R3", 1'b0);
        mr0_i = 13'h1D70;
        run(2'd0, C + 6, "R4", 1'b0);
        mr1_i = 13'h1FC3; mr2_i = 13'h0A5A; mr3_i = 13'h0101;
        run(2'd1, 2, "R6", 1'b0);
        mr11_i = 8'hA7;
        run(2'd2, C + 3, "R10", 1'b1);
        run(2'd3, 1, "R5", 1'b0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule